// File: doc/BRIEF.md
# Accumulator Fetch-Execute Core

This block is a small 8-bit processor core. It reads its program one byte at a time from an external memory through a 16-bit address and an 8-bit read-data path. It runs a short sequence of instructions that each take an immediate operand. The core has four 8-bit general registers. Only the first of them, the accumulator, is the target of the instruction set. It also has a 16-bit program counter, a decoder and an adder.

After a synchronous reset the core starts fetching at address 1400H. An instruction is either one byte long or an opcode followed by one immediate byte:

- Load-immediate copies the immediate byte into the accumulator.
- Add-immediate adds the immediate byte to the accumulator and records the carry.
- Halt stops all further fetching until the next reset.
- Any other opcode is a one-byte no-operation.

The memory port is a strobe/ready handshake. The core holds the read strobe and the address until the memory signals ready, so a memory with any latency can serve it. The accumulator and the carry flag are visible on output ports, so the result of a program can be observed.

Top module: `acc_core`

## Requirements
- R1: In the cycle after reset is released, the address is 1400H, the read strobe is high, halted is low, and both the accumulator and the carry read 0.
- R2: While the read strobe is high and ready is low, the strobe stays high and the address does not change. The data byte is taken only in the cycle in which ready is high.
- R3: Opcode B0H loads the following byte into the accumulator and leaves the carry unchanged.
- R4: Opcode 04H replaces the accumulator with (accumulator + following byte) modulo 256. The carry becomes bit 8 of that sum.
- R5: Each accepted byte advances the address by one, so a two-byte instruction moves the address by two (1400H, 1402H, 1404H, ...).
- R6: Opcode F4H sets halted. From then until reset, the read strobe stays low and the address is frozen at one past the F4H byte.
- R7: Any opcode other than B0H, 04H and F4H is a one-byte no-operation: the address advances by one, and the accumulator and carry are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Address of the byte being fetched |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_data | input | 8 | Byte returned by memory |
| mem_rdy | input | 1 | Memory signals that mem_data is valid |
| halted | output | 1 | High once a halt opcode has executed |
| acc_view | output | 8 | Current accumulator value |
| carry_view | output | 1 | Carry out of the most recent add |

## Verification
The main sweep runs load-then-add programs over a grid of operand pairs. The grid covers sums on both sides of 256 and edge values such as 00H and FFH, so the modulo wrap and the carry are separated from a plain add. Each run also varies the memory latency from zero to three wait cycles, which shows that data is captured on the ready cycle and not on the strobe cycle. Separate programs tell apart three cases:

- a load that must keep an earlier carry;
- a second add that must clear that carry;
- an unknown opcode that must step the address by one.

A post-halt watch confirms that the strobe stays low and the address stays fixed.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 4;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam logic [REG_IDX_W-1:0] REG_ACC = '0;
    localparam logic [ADDR_W-1:0] RESET_VEC = 16'h1400;

    localparam logic [DATA_W-1:0] OPC_LOAD = 8'hB0;
    localparam logic [DATA_W-1:0] OPC_ADD  = 8'h04;
    localparam logic [DATA_W-1:0] OPC_HALT = 8'hF4;

    typedef enum logic [1:0] {
        ST_OPCODE = 2'd0,
        ST_IMMED  = 2'd1,
        ST_HALTED = 2'd2
    } seq_state_t;

    typedef enum logic {
        EX_LOAD = 1'b0,
        EX_ADD  = 1'b1
    } ex_kind_t;

    typedef struct packed {
        logic                  wr_en;
        ex_kind_t              kind;
        logic [DATA_W-1:0]     imm;
    } exec_req_t;

    function automatic logic [DATA_W:0] add_wide(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction
endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_rdy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              halted,
    output exec_req_t         req
);
    seq_state_t        st_q;
    logic [ADDR_W-1:0] pc_q;
    ex_kind_t          kind_q;
    logic              take;

    assign mem_rd   = (st_q != ST_HALTED);
    assign mem_addr = pc_q;
    assign halted   = (st_q == ST_HALTED);
    assign take     = mem_rd && mem_rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_OPCODE;
            pc_q   <= RESET_VEC;
            kind_q <= EX_LOAD;
        end else begin
            case (st_q)
                ST_OPCODE: if (take) begin
                    pc_q <= pc_q + 1'b1;
                    case (mem_data)
                        OPC_LOAD: begin st_q <= ST_IMMED; kind_q <= EX_LOAD; end
                        OPC_ADD:  begin st_q <= ST_IMMED; kind_q <= EX_ADD;  end
                        OPC_HALT: st_q <= ST_HALTED;
                        default:  st_q <= ST_OPCODE;
                    endcase
                end
                ST_IMMED: if (take) begin
                    pc_q <= pc_q + 1'b1;
                    st_q <= ST_OPCODE;
                end
                default: st_q <= ST_HALTED;
            endcase
        end
    end

    always_comb begin
        req.wr_en = (st_q == ST_IMMED) && take;
        req.kind  = kind_q;
        req.imm   = mem_data;
    end

    p_reset_vector_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == RESET_VEC && mem_rd && !halted));

    p_strobe_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_rdy) |=> (mem_rd && $stable(mem_addr)));

    p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && mem_rdy) |=> (mem_addr == $past(mem_addr) + 1'b1));

    p_halt_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !mem_rd && $stable(mem_addr)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_core_pkg::*;
(
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    logic [DATA_W:0] wide;

    assign wide = add_wide(op_a, op_b);
    assign sum  = wide[DATA_W-1:0];
    assign cout = wide[DATA_W];
endmodule

// File: rtl/acc_regs.sv
module acc_regs
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  exec_req_t         req,
    input  logic [DATA_W-1:0] sum,
    input  logic              cout,
    output logic [DATA_W-1:0] acc,
    output logic              carry
);
    logic [DATA_W-1:0] gpr_q [NUM_REGS];
    logic              carry_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_gpr
        always_ff @(posedge clk) begin
            if (rst) begin
                gpr_q[g] <= '0;
            end else if (req.wr_en && (REG_IDX_W'(g) == REG_ACC)) begin
                gpr_q[g] <= (req.kind == EX_ADD) ? sum : req.imm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
        end else if (req.wr_en && req.kind == EX_ADD) begin
            carry_q <= cout;
        end
    end

    assign acc   = gpr_q[REG_ACC];
    assign carry = carry_q;

    p_load_keeps_carry_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr_en && req.kind == EX_LOAD) |=> (acc == $past(req.imm) && $stable(carry)));

    p_idle_keeps_acc_r7: assert property (@(posedge clk) disable iff (rst)
        !req.wr_en |=> ($stable(acc) && $stable(carry)));
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_rdy,
    output logic              halted,
    output logic [DATA_W-1:0] acc_view,
    output logic              carry_view
);
    exec_req_t         req;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic [DATA_W-1:0] acc;
    logic              carry;

    acc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .mem_data (mem_data),
        .mem_rdy  (mem_rdy),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .halted   (halted),
        .req      (req)
    );

    acc_alu u_alu (
        .op_a (acc),
        .op_b (req.imm),
        .sum  (sum),
        .cout (cout)
    );

    acc_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .sum   (sum),
        .cout  (cout),
        .acc   (acc),
        .carry (carry)
    );

    assign acc_view   = acc;
    assign carry_view = carry;

    p_add_result_r4: assert property (@(posedge clk) disable iff (rst)
        (req.wr_en && req.kind == EX_ADD) |=>
        ({carry_view, acc_view} == ({1'b0, $past(acc_view)} + {1'b0, $past(mem_data)})));
endmodule

// File: tb/test_acc_core.sv
module test_acc_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  mem_data;
    logic        mem_rdy;
    logic        halted;
    logic [7:0]  acc_view;
    logic        carry_view;

    logic [7:0] prog [16];
    int         wait_n = 0;
    int         lat_cnt = 0;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    acc_core i_acc_core (
        .clk        (clk),
        .rst        (rst),
        .mem_addr   (mem_addr),
        .mem_rd     (mem_rd),
        .mem_data   (mem_data),
        .mem_rdy    (mem_rdy),
        .halted     (halted),
        .acc_view   (acc_view),
        .carry_view (carry_view)
    );

    always_comb begin
        if (mem_addr >= 16'h1400 && mem_addr < 16'h1410)
            mem_data = prog[mem_addr[3:0]];
        else
            mem_data = 8'h00;
        mem_rdy = mem_rd && (lat_cnt == wait_n);
    end

    always @(posedge clk) begin
        if (rst || !mem_rd || mem_rdy) lat_cnt <= 0;
        else lat_cnt <= lat_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 16; i++) prog[i] = 8'hF4;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_to_halt(input string req);
        int n;
        n = 0;
        do_reset();
        while (!halted && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'd0, halted}, 32'd1);
    endtask

    initial begin
        clear_prog();
        // R1: reset state
        wait_n = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 addr", {16'd0, mem_addr}, 32'h1400);
        check("R1 rd", {31'd0, mem_rd}, 1);
        check("R1 halted", {31'd0, halted}, 0);
        check("R1 acc", {24'd0, acc_view}, 0);
        check("R1 carry", {31'd0, carry_view}, 0);

        // R2: strobe and address held during wait cycles
        prog[0] = 8'hB0; prog[1] = 8'h3C; prog[2] = 8'hF4;
        wait_n = 3;
        do_reset();
        repeat (3) begin
            @(negedge clk);
            check("R2 addr hold", {16'd0, mem_addr}, 32'h1400);
            check("R2 rd hold", {31'd0, mem_rd}, 1);
        end
        @(negedge clk);
        check("R2 advance", {16'd0, mem_addr}, 32'h1401);
        repeat (40) @(negedge clk);
        check("R2 R3 load with wait", {24'd0, acc_view}, 32'h3C);

        // R4 R5 sweep of load-then-add programs
        for (int x = 0; x < 256; x += 17) begin
            for (int y = 0; y < 256; y += 15) begin
                int s;
                clear_prog();
                prog[0] = 8'hB0; prog[1] = 8'(x);
                prog[2] = 8'h04; prog[3] = 8'(y);
                wait_n = (x + y) % 4;
                run_to_halt("R6 halt reached");
                s = x + y;
                check("R4 sum", {24'd0, acc_view}, s % 256);
                check("R4 carry", {31'd0, carry_view}, s / 256);
                check("R5 final addr", {16'd0, mem_addr}, 32'h1405);
            end
        end
        // edge operand FF + FF
        clear_prog();
        prog[0] = 8'hB0; prog[1] = 8'hFF; prog[2] = 8'h04; prog[3] = 8'hFF;
        wait_n = 1;
        run_to_halt("R6 halt reached");
        check("R4 FF+FF sum", {24'd0, acc_view}, 32'hFE);
        check("R4 FF+FF carry", {31'd0, carry_view}, 1);

        // R3: load keeps carry; R4: later add clears carry
        clear_prog();
        prog[0] = 8'hB0; prog[1] = 8'hFF; prog[2] = 8'h04; prog[3] = 8'h02;
        prog[4] = 8'hB0; prog[5] = 8'h10;
        wait_n = 0;
        run_to_halt("R6 halt reached");
        check("R3 load value", {24'd0, acc_view}, 32'h10);
        check("R3 carry kept", {31'd0, carry_view}, 1);
        check("R5 addr after three", {16'd0, mem_addr}, 32'h1407);
        clear_prog();
        prog[0] = 8'hB0; prog[1] = 8'hFF; prog[2] = 8'h04; prog[3] = 8'h01;
        prog[4] = 8'h04; prog[5] = 8'h01;
        run_to_halt("R6 halt reached");
        check("R4 carry cleared", {31'd0, carry_view}, 0);
        check("R4 acc", {24'd0, acc_view}, 32'h01);

        // R7: unknown opcodes are one-byte no-ops
        clear_prog();
        prog[0] = 8'h00; prog[1] = 8'hB0; prog[2] = 8'h55; prog[3] = 8'h90;
        prog[4] = 8'hB1; prog[5] = 8'h04; prog[6] = 8'h05;
        wait_n = 2;
        run_to_halt("R6 halt reached");
        check("R7 acc", {24'd0, acc_view}, 32'h5A);
        check("R7 carry", {31'd0, carry_view}, 0);
        check("R7 addr", {16'd0, mem_addr}, 32'h1408);

        // R6: after halt no strobe, address frozen
        repeat (20) begin
            @(negedge clk);
            check("R6 no strobe", {31'd0, mem_rd}, 0);
            check("R6 addr frozen", {16'd0, mem_addr}, 32'h1408);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule